// File: doc/BRIEF.md
# Cascadable Column Data Capture Controller

This block takes in one display line of gray-scale values and places it into a bank of column channel registers. On each data-clock strobe, six 8-bit dot values arrive side by side on a single input word. A start pulse arms the block. From the next data strobe on, the block stores one group of six dots per strobe until every channel holds a value. It then goes idle and waits for the next start pulse. The strobes are synchronous enables, sampled on the system clock.

Several devices can be chained to drive a wide panel. A direction input picks the end at which the start pulse enters and the order in which channel groups fill. The opposite end then carries a one-interval pulse to the next device in the chain. Each end is modelled as a separate input, output and output-enable. Two inversion inputs complement the bits of either half of the dot group before it is stored. A line-latch strobe drops any load in progress and returns the fill position to its origin.

Top module: `lineCapture`

## Requirements
- R1: After reset, every channel register is 0, both cascade outputs are 0 and the block is idle: data strobes have no effect until a start pulse is seen.
- R2: A start pulse is sampled on a data strobe, and that strobe stores nothing. The first dot group is stored on the next data strobe.
- R3: With dirUp=1, the k-th stored group (k counted from 0) writes channels 6k to 6k+5. Dot d, taken from dataIn[8d+7:8d], goes to channel 6k+d, and channel c occupies chanData[8c+7:8c].
- R4: With dirUp=0, the k-th stored group writes channels 6(G-1-k) to 6(G-1-k)+5, where G is the number of channels divided by 6. Dot d goes to channel 6(G-1-k)+d.
- R5: After G groups are stored, the block is in stand-by. Further data strobes change no channel until a new start pulse arrives.
- R6: invLo=1 complements dots 0 to 2 before storage, and invHi=1 complements dots 3 to 5. With both low, the data is stored unchanged.
- R7: With dirUp=1, the start pulse is taken from startIn1, startOe1=0 and startOe2=1. With dirUp=0 the roles swap (startIn2, startOe2=0, startOe1=1). A pulse on the unselected input has no effect.
- R8: The cascade output on the output end is high from the strobe that stores group G-2 until the strobe that stores the final group, so it spans exactly that one data-clock interval. The output on the input end stays 0.
- R9: A line-latch strobe clears the fill position and stops the load in progress. Channels already written keep their values, and data strobes are ignored until the next start pulse.
- R10: A start pulse that arrives during a load restarts the fill at the first group, and the following strobes overwrite from the origin end.
- R11: System clock cycles without a data or line-latch strobe change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dataClkEn | input | 1 | Data-clock strobe, one system cycle per data edge |
| latchEn | input | 1 | Line-latch strobe; clears the fill position |
| dataIn | input | DOTS*DOT_W | Six dot values; dot d in bits [8d+7:8d] |
| invLo | input | 1 | Complement dots 0 to 2 |
| invHi | input | 1 | Complement dots 3 to 5 |
| dirUp | input | 1 | 1: enter at end 1, fill upward; 0: enter at end 2, fill downward |
| startIn1 | input | 1 | Start pulse in, end 1 |
| startOut1 | output | 1 | Cascade pulse out, end 1 |
| startOe1 | output | 1 | Output enable, end 1 |
| startIn2 | input | 1 | Start pulse in, end 2 |
| startOut2 | output | 1 | Cascade pulse out, end 2 |
| startOe2 | output | 1 | Output enable, end 2 |
| chanData | output | CHANNELS*DOT_W | Channel register bank, channel c at [8c+7:8c] |

## Verification
The bench builds the block with 24 channels, which gives four groups per line. With that size, every channel can be compared after each scenario, and the cascade pulse can be checked before and after every single store. The small line also puts stand-by, restart, line-latch and both fill directions within a few dozen strobes. All four inversion settings run against expected values computed arithmetically from a line, group and dot index pattern.

// File: rtl/lineCapPkg.sv
package lineCapPkg;
  localparam int SEL_W = 16;

  typedef struct packed {
    logic             loadEn;
    logic [SEL_W-1:0] blockSel;
  } capStrobe_t;
endpackage

// File: rtl/capCtrl.sv
module capCtrl
  import lineCapPkg::*;
#(
  parameter int GROUPS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataClkEn,
  input  logic       latchEn,
  input  logic       dirUp,
  input  logic       startIn1,
  input  logic       startIn2,
  output capStrobe_t strobes,
  output logic       startOut1,
  output logic       startOe1,
  output logic       startOut2,
  output logic       startOe2
);
  localparam int IDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUPS - 1);

  logic             running;
  logic [IDX_W-1:0] idx;
  logic             startSel;
  logic             lastPhase;

  assign startSel  = dirUp ? startIn1 : startIn2;
  assign lastPhase = running && (idx == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      idx     <= '0;
    end else if (latchEn) begin
      running <= 1'b0;
      idx     <= '0;
    end else if (dataClkEn) begin
      if (startSel) begin
        running <= 1'b1;
        idx     <= '0;
      end else if (running) begin
        if (idx == LAST) begin
          running <= 1'b0;
          idx     <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.loadEn   = dataClkEn && running && !startSel && !latchEn;
    strobes.blockSel = dirUp ? SEL_W'(idx) : SEL_W'(LAST - idx);
  end

  assign startOe1  = !dirUp;
  assign startOe2  = dirUp;
  assign startOut1 = !dirUp && lastPhase;
  assign startOut2 = dirUp && lastPhase;

  p_start_arms_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataClkEn && startSel && !latchEn) |=> (running && idx == '0));

  p_standby_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataClkEn && !latchEn && !startSel && running && idx == LAST) |=> !running);

  p_casc_one_interval_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((startOut1 || startOut2) && dataClkEn && !latchEn && !startSel) |=> !(startOut1 || startOut2));

  p_latch_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |=> (!running && idx == '0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!dataClkEn && !latchEn) |=> ($stable(idx) && $stable(running)));
endmodule

// File: rtl/capData.sv
module capData
  import lineCapPkg::*;
#(
  parameter int DOTS   = 6,
  parameter int DOT_W  = 8,
  parameter int GROUPS = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  capStrobe_t                      strobes,
  input  logic [DOTS*DOT_W-1:0]           dataIn,
  input  logic                            invLo,
  input  logic                            invHi,
  output logic [GROUPS*DOTS*DOT_W-1:0]    bank
);
  localparam int GW   = DOTS * DOT_W;
  localparam int HALF = DOTS / 2;

  logic [GW-1:0] invMask;
  logic [GW-1:0] word;

  for (genvar d = 0; d < DOTS; d++) begin : g_mask
    if (d < HALF) begin : g_lo
      assign invMask[d*DOT_W +: DOT_W] = {DOT_W{invLo}};
    end else begin : g_hi
      assign invMask[d*DOT_W +: DOT_W] = {DOT_W{invHi}};
    end
  end

  assign word = dataIn ^ invMask;

  for (genvar b = 0; b < GROUPS; b++) begin : g_block
    localparam logic [SEL_W-1:0] BSEL = SEL_W'(b);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bank[b*GW +: GW] <= '0;
      end else if (strobes.loadEn && strobes.blockSel == BSEL) begin
        bank[b*GW +: GW] <= word;
      end
    end

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.loadEn && strobes.blockSel == BSEL) |=> (bank[b*GW +: GW] == $past(word)));
  end

  p_hold_without_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(bank));
endmodule

// File: rtl/lineCapture.sv
module lineCapture
  import lineCapPkg::*;
#(
  parameter int DOTS     = 6,
  parameter int DOT_W    = 8,
  parameter int CHANNELS = 384
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        dataClkEn,
  input  logic                        latchEn,
  input  logic [DOTS*DOT_W-1:0]       dataIn,
  input  logic                        invLo,
  input  logic                        invHi,
  input  logic                        dirUp,
  input  logic                        startIn1,
  output logic                        startOut1,
  output logic                        startOe1,
  input  logic                        startIn2,
  output logic                        startOut2,
  output logic                        startOe2,
  output logic [CHANNELS*DOT_W-1:0]   chanData
);
  localparam int GROUPS = CHANNELS / DOTS;

  capStrobe_t strobes;

  capCtrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataClkEn (dataClkEn),
    .latchEn   (latchEn),
    .dirUp     (dirUp),
    .startIn1  (startIn1),
    .startIn2  (startIn2),
    .strobes   (strobes),
    .startOut1 (startOut1),
    .startOe1  (startOe1),
    .startOut2 (startOut2),
    .startOe2  (startOe2)
  );

  capData #(.DOTS(DOTS), .DOT_W(DOT_W), .GROUPS(GROUPS)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .invLo   (invLo),
    .invHi   (invHi),
    .bank    (chanData)
  );
endmodule

// File: tb/lineCapture_test.sv
module lineCapture_test;
  localparam int DOTS = 6;
  localparam int DW   = 8;
  localparam int CH   = 24;
  localparam int GRP  = CH / DOTS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataClkEn = 1'b0;
  logic latchEn = 1'b0;
  logic [DOTS*DW-1:0] dataIn = '0;
  logic invLo = 1'b0;
  logic invHi = 1'b0;
  logic dirUp = 1'b1;
  logic startIn1 = 1'b0;
  logic startIn2 = 1'b0;
  logic startOut1, startOe1, startOut2, startOe2;
  logic [CH*DW-1:0] chanData;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] expBank [CH];

  always #4 clk = ~clk;

  lineCapture #(.DOTS(DOTS), .DOT_W(DW), .CHANNELS(CH)) uut (
    .clk(clk), .rstN(rstN), .dataClkEn(dataClkEn), .latchEn(latchEn),
    .dataIn(dataIn), .invLo(invLo), .invHi(invHi), .dirUp(dirUp),
    .startIn1(startIn1), .startOut1(startOut1), .startOe1(startOe1),
    .startIn2(startIn2), .startOut2(startOut2), .startOe2(startOe2),
    .chanData(chanData)
  );

  function automatic logic [DW-1:0] pat(int line, int g, int d);
    return DW'((line * 37 + g * 11 + d * 5 + 1) % 256);
  endfunction

  function automatic logic [DOTS*DW-1:0] lineWord(int line, int g);
    logic [DOTS*DW-1:0] w;
    for (int d = 0; d < DOTS; d++) w[d*DW +: DW] = pat(line, g, d);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expLoad(input int line, input int g, input bit up, input bit iL, input bit iH);
    int base = up ? g * DOTS : (GRP - 1 - g) * DOTS;
    for (int d = 0; d < DOTS; d++) begin
      logic [DW-1:0] m = ((d < DOTS / 2) ? iL : iH) ? {DW{1'b1}} : '0;
      expBank[base + d] = pat(line, g, d) ^ m;
    end
  endtask

  task automatic checkBank(input string req);
    for (int c = 0; c < CH; c++)
      chk(chanData[c*DW +: DW] == expBank[c], req, 64'(chanData[c*DW +: DW]), 64'(expBank[c]));
  endtask

  task automatic dEdge(input logic s1, input logic s2, input logic [DOTS*DW-1:0] d);
    @(negedge clk);
    dataClkEn = 1'b1; startIn1 = s1; startIn2 = s2; dataIn = d;
    @(negedge clk);
    dataClkEn = 1'b0; startIn1 = 1'b0; startIn2 = 1'b0;
  endtask

  task automatic startEdge();
    dEdge(dirUp, !dirUp, lineWord(99, 0));
  endtask

  // Full line load with cascade checks after each store (R8).
  task automatic loadLine(input int line);
    startEdge();
    for (int g = 0; g < GRP; g++) begin
      dEdge(1'b0, 1'b0, lineWord(line, g));
      expLoad(line, g, dirUp, invLo, invHi);
      if (dirUp) begin
        chk(startOut2 == (g == GRP - 2), "R8 out2", 64'(startOut2), 64'(g == GRP - 2));
        chk(startOut1 == 1'b0, "R8 out1 idle", 64'(startOut1), 64'd0);
      end else begin
        chk(startOut1 == (g == GRP - 2), "R8 out1", 64'(startOut1), 64'(g == GRP - 2));
        chk(startOut2 == 1'b0, "R8 out2 idle", 64'(startOut2), 64'd0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < CH; c++) expBank[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkBank("R1 reset bank");
    chk(startOut1 == 0 && startOut2 == 0, "R1 outs", 64'({startOut1, startOut2}), 64'd0);
    // R1/R2 strobes before any start are ignored
    dEdge(1'b0, 1'b0, lineWord(1, 0));
    dEdge(1'b0, 1'b0, lineWord(1, 1));
    checkBank("R1 idle ignores data");
    // R7 steering for dirUp=1
    chk(startOe1 == 0 && startOe2 == 1, "R7 oe up", 64'({startOe1, startOe2}), 64'b01);
    // R2: start strobe stores nothing
    startEdge();
    checkBank("R2 start edge stores nothing");
    // R2/R3 first group next strobe
    dEdge(1'b0, 1'b0, lineWord(2, 0));
    expLoad(2, 0, 1'b1, 1'b0, 1'b0);
    checkBank("R2 first group");
    for (int g = 1; g < GRP; g++) begin
      dEdge(1'b0, 1'b0, lineWord(2, g));
      expLoad(2, g, 1'b1, 1'b0, 1'b0);
    end
    checkBank("R3 upward fill");
    // R5 stand-by
    dEdge(1'b0, 1'b0, lineWord(3, 0));
    dEdge(1'b0, 1'b0, lineWord(3, 1));
    checkBank("R5 stand-by ignores data");
    // R11 idle system cycles
    repeat (5) @(negedge clk);
    checkBank("R11 idle cycles");
    // R8 cascade upward with checks
    loadLine(4);
    checkBank("R3 second line");
    // R7 downward steering, unselected input ignored
    dirUp = 1'b0;
    @(negedge clk);
    chk(startOe1 == 1 && startOe2 == 0, "R7 oe down", 64'({startOe1, startOe2}), 64'b10);
    dEdge(1'b1, 1'b0, lineWord(98, 0));
    dEdge(1'b0, 1'b0, lineWord(5, 0));
    checkBank("R7 unselected start ignored");
    // R4 downward fill
    loadLine(6);
    checkBank("R4 downward fill");
    // R6 inversion in all settings
    dirUp = 1'b1;
    invLo = 1'b1; invHi = 1'b0; loadLine(7); checkBank("R6 invLo");
    invLo = 1'b0; invHi = 1'b1; loadLine(8); checkBank("R6 invHi");
    invLo = 1'b1; invHi = 1'b1; loadLine(9); checkBank("R6 both");
    invLo = 1'b0; invHi = 1'b0;
    // R9 line latch mid-load
    startEdge();
    dEdge(1'b0, 1'b0, lineWord(10, 0)); expLoad(10, 0, 1'b1, 1'b0, 1'b0);
    dEdge(1'b0, 1'b0, lineWord(10, 1)); expLoad(10, 1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); latchEn = 1'b1;
    @(negedge clk); latchEn = 1'b0;
    chk(startOut2 == 1'b0, "R9 no cascade after latch", 64'(startOut2), 64'd0);
    dEdge(1'b0, 1'b0, lineWord(11, 2));
    dEdge(1'b0, 1'b0, lineWord(11, 3));
    checkBank("R9 latch stops load");
    loadLine(12);
    checkBank("R9 resumes after start");
    // R10 restart mid-load, downward
    dirUp = 1'b0;
    startEdge();
    dEdge(1'b0, 1'b0, lineWord(13, 0));
    dEdge(1'b0, 1'b0, lineWord(13, 1));
    loadLine(14);
    checkBank("R10 restart from origin");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule